// File: doc/BRIEF.md
# Accelerometer SPI Bring-up and Sample Reader

This block drives a three-axis digital accelerometer over a four-wire SPI link as the bus master. After reset it keeps chip select high for a programmable power-up delay. It then reads the identity register and compares the result with the expected value. If the identity matches, it writes a fixed three-step configuration. If it does not match, it raises a sticky link-error flag and issues no further transactions.

Once configured, the block waits for rising edges on the sensor's data-ready interrupt. Each rising edge triggers one burst read that fetches all six output bytes under a single chip-select assertion. The block rebuilds each axis from its little-endian byte pair and sign-extends the 13-bit value to 16 bits. The three samples appear on a strobed output port. Other logic on the chip can also ask for a single register write through a request/acknowledge pair. Such a write is slotted in only between burst reads.

Top module: `accel_spi_ctrl`

## Requirements
- R1: The link runs in clock mode 3. SCLK idles high whenever chip select is high. MOSI changes only on falling SCLK edges. MISO is sampled on rising edges. Bytes travel most significant bit first.
- R2: After reset is released, `spi_csn` stays high and SCLK stays idle for exactly `PWRUP_CYCLES` clock cycles. The first transaction then starts.
- R3: The first transaction is two bytes long, with command 0x80 (bit 7 = read, address 0). If the returned byte is not 0xE6, `link_err` rises and stays high, `init_done` stays low, and no other transaction follows, whatever the interrupt or write inputs do.
- R4: After a good identity read, three two-byte write transactions follow in this order: 0x31 then 0x0B, 0x2D then 0x08, 0x2E then 0x80. A write command byte has bit 7 = 0, bit 6 = 0 and the address in bits 5:0. `init_done` rises when the third write ends.
- R5: After `init_done`, a low-to-high change on `int_drdy` produces one seven-byte transaction. Its command byte is 0xF2 (bit 7 read, bit 6 multi-byte, address 0x32), and all seven bytes fall under one chip-select assertion.
- R6: Holding `int_drdy` high produces no further bursts. Only a new rising edge starts another one.
- R7: The burst bytes arrive in the order X low, X high, Y low, Y high, Z low, Z high. One cycle after chip select rises at the end of the burst, `smp_valid` pulses for one cycle. `smp_x`, `smp_y` and `smp_z` then hold the new samples until the next burst completes.
- R8: Each sample is bits 12:0 of {high byte, low byte}, sign-extended from bit 12 to 16 bits. For example, 0x1234 becomes 0xF234, 0xE00A becomes 0x000A, 0x0FFF stays 0x0FFF and 0xF000 stays 0xF000.
- R9: While `wr_req` is held high after `init_done`, the block sends the two-byte transaction {2'b00, `wr_addr`}, `wr_data`. It pulses `wr_ack` for one cycle when chip select rises at its end.
- R10: A write request that arrives during a burst is not inserted into that burst. The burst completes with all seven bytes, and the write follows as its own transaction.
- R11: Between two transactions, chip select stays high for at least 2×`HALF_DIV` clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| int_drdy | input | 1 | Data-ready interrupt from the sensor (asynchronous) |
| spi_sclk | output | 1 | SPI serial clock, idle high |
| spi_csn | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | Serial data to the sensor |
| spi_miso | input | 1 | Serial data from the sensor |
| wr_req | input | 1 | Register write request, held until acknowledged |
| wr_addr | input | 6 | Register address for the write request |
| wr_data | input | 8 | Data byte for the write request |
| wr_ack | output | 1 | One-cycle pulse when the requested write has finished |
| init_done | output | 1 | Bring-up finished, sample reads enabled |
| link_err | output | 1 | Identity check failed (sticky until reset) |
| smp_valid | output | 1 | One-cycle strobe marking new samples |
| smp_x | output | 16 | Signed X sample |
| smp_y | output | 16 | Signed Y sample |
| smp_z | output | 16 | Signed Z sample |

## Verification
The bench builds the block with `HALF_DIV` = 2 and `PWRUP_CYCLES` = 40 instead of the default millisecond-scale delay. This brings the following into a short run: the power-up wait, the full bring-up script, several bursts, interleaved writes and a second reset that exercises the identity-failure path. The smallest divider gives the tightest spacing between falling edges, rising edges and chip-select release. This is where a misplaced shift or a short chip-select gap would show up in the bytes the slave model decodes.

// File: rtl/accel_spi_pkg.sv
// Shared constants, types and helpers for the accelerometer SPI controller.
// Assumes a sensor with 6-bit register addresses and read/multi flags in the
// top two bits of the command byte.
package accel_spi_pkg;

    typedef enum logic [1:0] {
        TK_ID    = 2'd0,
        TK_INIT  = 2'd1,
        TK_BURST = 2'd2,
        TK_UWR   = 2'd3
    } txn_kind_t;

    typedef enum logic [2:0] {
        ST_PWR  = 3'd0,
        ST_CMD  = 3'd1,
        ST_WAIT = 3'd2,
        ST_GAP  = 3'd3,
        ST_IDLE = 3'd4,
        ST_ERR  = 3'd5
    } seq_state_t;

    localparam int          NUM_DATA_BYTES = 6;
    localparam int          NUM_AXES       = 3;
    localparam int          INIT_STEPS     = 3;
    localparam logic [7:0]  ID_EXPECT      = 8'hE6;
    localparam logic [5:0]  ADDR_ID        = 6'h00;
    localparam logic [5:0]  ADDR_DATA0     = 6'h32;
    localparam logic [7:0]  CMD_RD         = 8'h80;
    localparam logic [7:0]  CMD_MB         = 8'h40;

    // Register address of each configuration step.
    function automatic logic [5:0] init_addr(input logic [1:0] step);
        case (step)
            2'd0:    init_addr = 6'h31;
            2'd1:    init_addr = 6'h2D;
            default: init_addr = 6'h2E;
        endcase
    endfunction

    // Data byte of each configuration step.
    function automatic logic [7:0] init_data(input logic [1:0] step);
        case (step)
            2'd0:    init_data = 8'h0B;
            2'd1:    init_data = 8'h08;
            default: init_data = 8'h80;
        endcase
    endfunction

endpackage

// File: rtl/spi_byte_xfer.sv
// One-byte SPI shifter in clock mode 3 (idle high, drive on fall, sample on
// rise), MSB first. Each SCLK half period lasts HALF_DIV clock cycles.
// Assumes start is offered only while the shifter is idle.
module spi_byte_xfer #(
    parameter int HALF_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       done,
    output logic [7:0] rx_byte
);
    localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic          busy;
    logic [DW-1:0] div_cnt;
    logic [2:0]    bit_cnt;
    logic [7:0]    tx_sh;
    logic [7:0]    rx_sh;

    assign rx_byte = rx_sh;

    // Half-period timer, edge generation, shift out on fall, shift in on rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            div_cnt <= '0;
            bit_cnt <= '0;
            tx_sh   <= '0;
            rx_sh   <= '0;
            sclk    <= 1'b1;
            mosi    <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy    <= 1'b1;
                    tx_sh   <= tx_byte;
                    div_cnt <= '0;
                    bit_cnt <= '0;
                end
            end else if (div_cnt == DW'(HALF_DIV - 1)) begin
                div_cnt <= '0;
                sclk    <= ~sclk;
                if (sclk) begin
                    mosi  <= tx_sh[7];
                    tx_sh <= {tx_sh[6:0], 1'b0};
                end else begin
                    rx_sh   <= {rx_sh[6:0], miso};
                    bit_cnt <= bit_cnt + 3'd1;
                    if (bit_cnt == 3'd7) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end
                end
            end else begin
                div_cnt <= div_cnt + DW'(1);
            end
        end
    end

endmodule

// File: rtl/axis_unpack.sv
// Rebuilds the three axis samples from six little-endian bytes and
// sign-extends each from bit DATA_BITS-1. Outputs are registered and held.
// Assumes raw is stable in the cycle where load is high.
module axis_unpack
    import accel_spi_pkg::*;
#(
    parameter int DATA_BITS = 13,
    parameter int OUT_BITS  = 16
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                load,
    input  logic [NUM_DATA_BYTES-1:0][7:0]      raw,
    output logic                                valid,
    output logic [NUM_AXES-1:0][OUT_BITS-1:0]   samples
);
    localparam int EXT = OUT_BITS - DATA_BITS;

    logic [NUM_AXES-1:0][OUT_BITS-1:0] ext;

    for (genvar a = 0; a < NUM_AXES; a++) begin : g_axis
        logic [15:0] word;
        // Pair the high and low byte of this axis.
        assign word = {raw[2*a+1], raw[2*a]};
        // Replicate the sign bit above the data field.
        assign ext[a] = {{EXT{word[DATA_BITS-1]}}, word[DATA_BITS-1:0]};
    end

    // Capture the converted samples and raise the strobe for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid   <= 1'b0;
            samples <= '0;
        end else begin
            valid <= load;
            if (load) begin
                samples <= ext;
            end
        end
    end

endmodule

// File: rtl/accel_seq.sv
// Transaction sequencer: power-up wait, identity read, configuration writes,
// then interrupt-driven burst reads and requested single writes.
// Assumes the byte shifter accepts byte_start whenever the state is ST_CMD.
module accel_seq
    import accel_spi_pkg::*;
#(
    parameter int PWRUP_CYCLES = 110000,
    parameter int GAP_CYCLES   = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            drdy_i,
    input  logic                            wr_req,
    input  logic [5:0]                      wr_addr,
    input  logic [7:0]                      wr_data,
    output logic                            wr_ack,
    output logic                            byte_start,
    output logic [7:0]                      byte_tx,
    input  logic                            byte_done,
    input  logic [7:0]                      byte_rx,
    output logic                            csn,
    output logic                            init_done,
    output logic                            link_err,
    output logic                            smp_load,
    output logic [NUM_DATA_BYTES-1:0][7:0]  smp_raw
);
    localparam int PW = $clog2(PWRUP_CYCLES + 1);
    localparam int GW = $clog2(GAP_CYCLES + 1);

    seq_state_t    state;
    txn_kind_t     kind;
    logic [2:0]    idx;
    logic [1:0]    step;
    logic [PW-1:0] pwr_cnt;
    logic [GW-1:0] gap_cnt;
    logic [2:0]    drdy_sync;
    logic          drdy_rise;
    logic          burst_pend;
    logic [5:0]    u_addr;
    logic [7:0]    u_data;
    logic [2:0]    last_idx;

    assign drdy_rise  = drdy_sync[1] & ~drdy_sync[2];
    assign last_idx   = (kind == TK_BURST) ? 3'(NUM_DATA_BYTES) : 3'd1;
    assign byte_start = (state == ST_CMD);

    // Byte to shift out for the current transaction kind and position.
    always_comb begin
        byte_tx = 8'h00;
        case (kind)
            TK_ID:    if (idx == 3'd0) byte_tx = CMD_RD | {2'b00, ADDR_ID};
            TK_INIT:  byte_tx = (idx == 3'd0) ? {2'b00, init_addr(step)} : init_data(step);
            TK_UWR:   byte_tx = (idx == 3'd0) ? {2'b00, u_addr} : u_data;
            default:  if (idx == 3'd0) byte_tx = CMD_RD | CMD_MB | {2'b00, ADDR_DATA0};
        endcase
    end

    // Main sequencing: transaction framing, result capture and next-step choice.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_PWR;
            kind       <= TK_ID;
            idx        <= '0;
            step       <= '0;
            pwr_cnt    <= '0;
            gap_cnt    <= '0;
            drdy_sync  <= '0;
            burst_pend <= 1'b0;
            u_addr     <= '0;
            u_data     <= '0;
            csn        <= 1'b1;
            init_done  <= 1'b0;
            link_err   <= 1'b0;
            smp_load   <= 1'b0;
            wr_ack     <= 1'b0;
            smp_raw    <= '0;
        end else begin
            smp_load  <= 1'b0;
            wr_ack    <= 1'b0;
            drdy_sync <= {drdy_sync[1:0], drdy_i};
            case (state)
                ST_PWR: begin
                    if (pwr_cnt == PW'(PWRUP_CYCLES - 1)) begin
                        kind  <= TK_ID;
                        idx   <= '0;
                        csn   <= 1'b0;
                        state <= ST_CMD;
                    end else begin
                        pwr_cnt <= pwr_cnt + PW'(1);
                    end
                end
                ST_CMD: state <= ST_WAIT;
                ST_WAIT: begin
                    if (byte_done) begin
                        if (kind == TK_BURST && idx != 3'd0) begin
                            smp_raw[idx - 3'd1] <= byte_rx;
                        end
                        if (idx == last_idx) begin
                            csn     <= 1'b1;
                            gap_cnt <= '0;
                            state   <= ST_GAP;
                            case (kind)
                                TK_ID: if (byte_rx != ID_EXPECT) begin
                                    link_err <= 1'b1;
                                    state    <= ST_ERR;
                                end
                                TK_INIT: if (step == 2'(INIT_STEPS - 1)) begin
                                    init_done <= 1'b1;
                                end else begin
                                    step <= step + 2'd1;
                                end
                                TK_BURST: smp_load <= 1'b1;
                                default:  wr_ack   <= 1'b1;
                            endcase
                        end else begin
                            idx   <= idx + 3'd1;
                            state <= ST_CMD;
                        end
                    end
                end
                ST_GAP: begin
                    if (gap_cnt == GW'(GAP_CYCLES - 1)) begin
                        if (!init_done) begin
                            kind  <= TK_INIT;
                            idx   <= '0;
                            csn   <= 1'b0;
                            state <= ST_CMD;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end else begin
                        gap_cnt <= gap_cnt + GW'(1);
                    end
                end
                ST_IDLE: begin
                    if (burst_pend) begin
                        burst_pend <= 1'b0;
                        kind       <= TK_BURST;
                        idx        <= '0;
                        csn        <= 1'b0;
                        state      <= ST_CMD;
                    end else if (wr_req) begin
                        u_addr <= wr_addr;
                        u_data <= wr_data;
                        kind   <= TK_UWR;
                        idx    <= '0;
                        csn    <= 1'b0;
                        state  <= ST_CMD;
                    end
                end
                default: state <= ST_ERR;
            endcase
            if (drdy_rise) begin
                burst_pend <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/accel_spi_ctrl.sv
// Top level of the accelerometer SPI controller: sequencer, byte shifter and
// sample rebuild. Assumes int_drdy may be asynchronous; it is synchronised
// inside the sequencer.
module accel_spi_ctrl
    import accel_spi_pkg::*;
#(
    parameter int HALF_DIV     = 4,
    parameter int PWRUP_CYCLES = 110000,
    parameter int DATA_BITS    = 13
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        int_drdy,
    output logic        spi_sclk,
    output logic        spi_csn,
    output logic        spi_mosi,
    input  logic        spi_miso,
    input  logic        wr_req,
    input  logic [5:0]  wr_addr,
    input  logic [7:0]  wr_data,
    output logic        wr_ack,
    output logic        init_done,
    output logic        link_err,
    output logic        smp_valid,
    output logic [15:0] smp_x,
    output logic [15:0] smp_y,
    output logic [15:0] smp_z
);
    localparam int GAP_CYCLES = 2 * HALF_DIV;

    logic                           byte_start;
    logic [7:0]                     byte_tx;
    logic                           byte_done;
    logic [7:0]                     byte_rx;
    logic                           smp_load;
    logic [NUM_DATA_BYTES-1:0][7:0] smp_raw;
    logic [NUM_AXES-1:0][15:0]      samples;

    accel_seq #(
        .PWRUP_CYCLES (PWRUP_CYCLES),
        .GAP_CYCLES   (GAP_CYCLES)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .drdy_i     (int_drdy),
        .wr_req     (wr_req),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .wr_ack     (wr_ack),
        .byte_start (byte_start),
        .byte_tx    (byte_tx),
        .byte_done  (byte_done),
        .byte_rx    (byte_rx),
        .csn        (spi_csn),
        .init_done  (init_done),
        .link_err   (link_err),
        .smp_load   (smp_load),
        .smp_raw    (smp_raw)
    );

    spi_byte_xfer #(
        .HALF_DIV (HALF_DIV)
    ) u_xfer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (byte_start),
        .tx_byte (byte_tx),
        .miso    (spi_miso),
        .sclk    (spi_sclk),
        .mosi    (spi_mosi),
        .done    (byte_done),
        .rx_byte (byte_rx)
    );

    axis_unpack #(
        .DATA_BITS (DATA_BITS),
        .OUT_BITS  (16)
    ) u_unpack (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (smp_load),
        .raw     (smp_raw),
        .valid   (smp_valid),
        .samples (samples)
    );

    assign smp_x = samples[0];
    assign smp_y = samples[1];
    assign smp_z = samples[2];

endmodule

// File: rtl/accel_spi_ctrl_chk.sv
// Protocol checker for accel_spi_ctrl, attached by bind. Watches only the
// top-level ports; windows are measured with saturating counters.
module accel_spi_ctrl_chk #(
    parameter int HALF_DIV     = 4,
    parameter int PWRUP_CYCLES = 110000
) (
    input logic clk,
    input logic rst_n,
    input logic spi_sclk,
    input logic spi_csn,
    input logic spi_mosi,
    input logic wr_ack,
    input logic init_done,
    input logic link_err,
    input logic smp_valid
);
    localparam int GAP_MIN = 2 * HALF_DIV;

    int unsigned since_rst;
    int unsigned hi_cnt;

    // Cycles since reset release, saturating at the power-up length.
    always_ff @(posedge clk) begin
        if (!rst_n)                        since_rst <= 0;
        else if (since_rst < PWRUP_CYCLES) since_rst <= since_rst + 1;
    end

    // Length of the current chip-select-high stretch, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                 hi_cnt <= 0;
        else if (!spi_csn)          hi_cnt <= 0;
        else if (hi_cnt < GAP_MIN)  hi_cnt <= hi_cnt + 1;
    end

    AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        spi_csn |-> spi_sclk);                                           // R1
    AST_MOSI_HOLD_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_sclk) |-> $stable(spi_mosi));                          // R1
    AST_PWRUP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_csn |-> since_rst >= PWRUP_CYCLES);                         // R2
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        link_err |=> link_err);                                          // R3
    AST_ERR_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        link_err |-> !init_done);                                        // R3
    AST_VALID_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |-> spi_csn);                                          // R7
    AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ack |=> !wr_ack);                                             // R9
    AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_csn) |-> hi_cnt >= GAP_MIN);                           // R11

endmodule

bind accel_spi_ctrl accel_spi_ctrl_chk #(
    .HALF_DIV     (HALF_DIV),
    .PWRUP_CYCLES (PWRUP_CYCLES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .spi_sclk  (spi_sclk),
    .spi_csn   (spi_csn),
    .spi_mosi  (spi_mosi),
    .wr_ack    (wr_ack),
    .init_done (init_done),
    .link_err  (link_err),
    .smp_valid (smp_valid)
);

// File: tb/accel_spi_ctrl_tb.sv
// Bench for accel_spi_ctrl: behavioural mode-3 SPI slave with a register
// array, transaction log, and a per-clock monitor comparing samples against
// an expected-value list computed from the requirements.
module accel_spi_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_DIV   = 2;
    localparam int PWRUP      = 40;
    localparam int WD_LIMIT   = 150000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        int_drdy;
    logic        spi_sclk, spi_csn, spi_mosi, spi_miso;
    logic        wr_req;
    logic [5:0]  wr_addr;
    logic [7:0]  wr_data;
    logic        wr_ack, init_done, link_err, smp_valid;
    logic [15:0] smp_x, smp_y, smp_z;

    always #(CLK_PERIOD/2) clk = ~clk;

    accel_spi_ctrl #(
        .HALF_DIV     (HALF_DIV),
        .PWRUP_CYCLES (PWRUP),
        .DATA_BITS    (13)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .int_drdy (int_drdy),
        .spi_sclk (spi_sclk), .spi_csn (spi_csn), .spi_mosi (spi_mosi),
        .spi_miso (spi_miso), .wr_req (wr_req), .wr_addr (wr_addr),
        .wr_data (wr_data), .wr_ack (wr_ack), .init_done (init_done),
        .link_err (link_err), .smp_valid (smp_valid),
        .smp_x (smp_x), .smp_y (smp_y), .smp_z (smp_z)
    );

    // Slave register array (owned by the main process) and transaction log (owned by the slave).
    logic [7:0] mem [64];
    int         t_n;
    int         t_len [64];
    logic [7:0] t_b0  [64];
    logic [7:0] t_b1  [64];

    // Expected samples: written by main, consumed by the monitor.
    logic [15:0] exp_x [16];
    logic [15:0] exp_y [16];
    logic [15:0] exp_z [16];
    int          exp_wr = 0;

    int checks = 0, bad = 0;
    int mon_checks = 0, mon_bad = 0;
    int smp_cnt = 0, ack_cnt = 0;
    int exp_rd = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Sign-extend bits 12:0 of a byte pair, computed arithmetically.
    function automatic logic [15:0] ref_ext(input logic [7:0] hi, input logic [7:0] lo);
        int v;
        v = int'({hi, lo}) & 32'h1FFF;
        if (v >= 32'h1000) v = v - 32'h2000;
        return v[15:0];
    endfunction

    task automatic load_axes(input logic [15:0] x, input logic [15:0] y, input logic [15:0] z);
        mem[6'h32] = x[7:0]; mem[6'h33] = x[15:8];
        mem[6'h34] = y[7:0]; mem[6'h35] = y[15:8];
        mem[6'h36] = z[7:0]; mem[6'h37] = z[15:8];
        exp_x[exp_wr] = ref_ext(x[15:8], x[7:0]);
        exp_y[exp_wr] = ref_ext(y[15:8], y[7:0]);
        exp_z[exp_wr] = ref_ext(z[15:8], z[7:0]);
        exp_wr++;
    endtask

    task automatic wait_sample();
        int s;
        s = smp_cnt;
        while (smp_cnt == s) @(negedge clk);
    endtask

    // Behavioural mode-3 SPI slave: samples MOSI on rise, drives MISO on fall.
    initial begin : slave
        logic [7:0] sh, outb;
        logic       rd, mb;
        logic [5:0] ad;
        int         bits, nb;
        spi_miso = 1'b0;
        t_n = 0;
        forever begin
            @(negedge spi_csn);
            bits = 0; nb = 0; sh = '0; outb = '0; rd = 1'b0; mb = 1'b0; ad = '0;
            while (spi_csn == 1'b0) begin
                @(spi_sclk or spi_csn);
                if (spi_csn) break;
                if (spi_sclk) begin
                    sh = {sh[6:0], spi_mosi};
                    bits++;
                    if (bits == 8) begin
                        bits = 0;
                        if (nb == 0) begin
                            rd = sh[7]; mb = sh[6]; ad = sh[5:0];
                            if (t_n < 64) t_b0[t_n] = sh;
                            if (rd) outb = mem[ad];
                        end else begin
                            if (nb == 1 && t_n < 64) t_b1[t_n] = sh;
                            if (rd) begin
                                if (mb) ad = ad + 6'd1;
                                outb = mem[ad];
                            end
                        end
                        nb++;
                    end
                end else begin
                    spi_miso = outb[7];
                    outb = {outb[6:0], 1'b0};
                end
            end
            if (t_n < 64) t_len[t_n] = nb;
            t_n++;
        end
    end

    // Per-clock monitor: sample comparison, ack count and chip-select gap (R7, R8, R11).
    initial begin : monitor
        int  hi_run;
        bit  seen;
        hi_run = 0; seen = 1'b0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                hi_run = 0; seen = 1'b0;
            end else begin
                if (smp_valid) begin
                    smp_cnt++;
                    mon_checks++;
                    if (exp_rd >= exp_wr) begin
                        mon_bad++;
                        $display("FAIL R7 unexpected smp_valid actual=1 expected=0");
                    end else begin
                        if (smp_x !== exp_x[exp_rd] || smp_y !== exp_y[exp_rd] || smp_z !== exp_z[exp_rd]) begin
                            mon_bad++;
                            $display("FAIL R8 sample actual=%h/%h/%h expected=%h/%h/%h",
                                     smp_x, smp_y, smp_z, exp_x[exp_rd], exp_y[exp_rd], exp_z[exp_rd]);
                        end
                        exp_rd++;
                    end
                end
                if (wr_ack) ack_cnt++;
                if (spi_csn) hi_run++;
                else begin
                    if (hi_run > 0) begin
                        if (seen) begin
                            mon_checks++;
                            if (hi_run < 2*HALF_DIV) begin
                                mon_bad++;
                                $display("FAIL R11 cs gap actual=%0d expected>=%0d", hi_run, 2*HALF_DIV);
                            end
                        end
                        seen = 1'b1;
                    end
                    hi_run = 0;
                end
            end
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin : watchdog
        repeat (WD_LIMIT) @(posedge clk);
        $display("FAIL watchdog expired actual=%0d expected<%0d", WD_LIMIT, WD_LIMIT);
        $display("  test done: total=%0d bad=%0d", checks + mon_checks + 1, bad + mon_bad + 1);
        $finish;
    end

    initial begin : main
        int cyc, base, sc, ac;
        for (int i = 0; i < 64; i++) mem[i] = 8'h00;
        mem[0] = 8'hE6;
        rst_n = 1'b0; int_drdy = 1'b0; wr_req = 1'b0; wr_addr = '0; wr_data = '0;
        repeat (3) @(negedge clk);

        // Reset state (R2: chip select high, R1: clock idle high).
        check(spi_csn == 1'b1 && spi_sclk == 1'b1, "R2", "reset csn/sclk", {spi_csn, spi_sclk}, 2'b11);
        check(!init_done && !link_err && !smp_valid && !wr_ack, "R3", "reset flags",
              {init_done, link_err, smp_valid, wr_ack}, 0);

        rst_n = 1'b1;
        cyc = 0;
        while (spi_csn) begin @(negedge clk); cyc++; end
        check(cyc >= PWRUP && cyc <= PWRUP + 2, "R2", "power-up quiet cycles", cyc, PWRUP);

        while (!init_done) @(negedge clk);
        check(t_n == 4, "R4", "bring-up transaction count", t_n, 4);
        check(t_b0[0] == 8'h80 && t_len[0] == 2, "R3", "identity read command", t_b0[0], 8'h80);
        check(t_b0[1] == 8'h31 && t_b1[1] == 8'h0B, "R4", "first config write", {t_b0[1], t_b1[1]}, 16'h310B);
        check(t_b0[2] == 8'h2D && t_b1[2] == 8'h08, "R4", "second config write", {t_b0[2], t_b1[2]}, 16'h2D08);
        check(t_b0[3] == 8'h2E && t_b1[3] == 8'h80, "R4", "third config write", {t_b0[3], t_b1[3]}, 16'h2E80);
        check(!link_err, "R3", "no link error on good identity", link_err, 0);

        // Pattern A: range limits (R5, R7, R8).
        load_axes(16'h0FFF, 16'hF000, 16'h0001);
        @(negedge clk); int_drdy = 1'b1;
        wait_sample();
        check(t_len[t_n-1] == 7 && t_b0[t_n-1] == 8'hF2, "R5", "burst framing",
              {t_len[t_n-1][7:0], t_b0[t_n-1]}, 16'h07F2);
        check(smp_x == 16'h0FFF && smp_y == 16'hF000 && smp_z == 16'h0001, "R7", "pattern A x",
              smp_x, 16'h0FFF);

        // Level held high: no further bursts (R6).
        base = t_n; sc = smp_cnt;
        repeat (600) @(negedge clk);
        check(t_n == base && smp_cnt == sc, "R6", "no burst on held level", t_n - base, 0);
        int_drdy = 1'b0;
        repeat (10) @(negedge clk);

        // Pattern B: out-of-range codes, sign taken from bit 12 (R8).
        load_axes(16'h1234, 16'hE00A, 16'hFFFF);
        int_drdy = 1'b1;
        wait_sample();
        int_drdy = 1'b0;
        check(smp_x == 16'hF234, "R8", "x sign from bit 12", smp_x, 16'hF234);
        check(smp_y == 16'h000A, "R8", "y upper bits dropped", smp_y, 16'h000A);
        check(smp_z == 16'hFFFF, "R8", "z minus one", smp_z, 16'hFFFF);
        repeat (10) @(negedge clk);

        // Requested single write (R9).
        ac = ack_cnt;
        wr_addr = 6'h1E; wr_data = 8'hFA; wr_req = 1'b1;
        @(negedge clk);
        while (!wr_ack) @(negedge clk);
        wr_req = 1'b0;
        repeat (20) @(negedge clk);
        check(t_b0[t_n-1] == 8'h1E && t_b1[t_n-1] == 8'hFA && t_len[t_n-1] == 2, "R9",
              "write transaction", {t_b0[t_n-1], t_b1[t_n-1]}, 16'h1EFA);
        check(ack_cnt == ac + 1, "R9", "single ack pulse", ack_cnt - ac, 1);

        // Write request raised during a burst (R10).
        load_axes(16'h0800, 16'h0FFF, 16'hF001);
        base = t_n;
        int_drdy = 1'b1;
        while (spi_csn) @(negedge clk);
        repeat (3) @(negedge clk);
        wr_addr = 6'h1F; wr_data = 8'h05; wr_req = 1'b1;
        while (!wr_ack) @(negedge clk);
        wr_req = 1'b0; int_drdy = 1'b0;
        repeat (20) @(negedge clk);
        check(t_n == base + 2, "R10", "burst then write count", t_n - base, 2);
        check(t_len[base] == 7 && t_b0[base] == 8'hF2, "R10", "burst intact",
              t_len[base], 7);
        check(t_b0[base+1] == 8'h1F && t_b1[base+1] == 8'h05, "R10", "write after burst",
              {t_b0[base+1], t_b1[base+1]}, 16'h1F05);
        check(exp_rd == exp_wr, "R7", "all expected samples seen", exp_rd, exp_wr);

        // Identity failure after a fresh reset (R3).
        rst_n = 1'b0; mem[0] = 8'h00;
        repeat (3) @(negedge clk);
        base = t_n; sc = smp_cnt; ac = ack_cnt;
        rst_n = 1'b1;
        while (!link_err) @(negedge clk);
        repeat (300) @(negedge clk);
        check(t_n == base + 1, "R3", "only identity read after mismatch", t_n - base, 1);
        check(link_err && !init_done, "R3", "error flags", {link_err, init_done}, 2'b10);
        int_drdy = 1'b1; wr_addr = 6'h10; wr_data = 8'h11; wr_req = 1'b1;
        repeat (300) @(negedge clk);
        check(t_n == base + 1 && smp_cnt == sc && ack_cnt == ac, "R3",
              "no activity in error state", t_n - base, 1);
        check(link_err == 1'b1, "R3", "error stays set", link_err, 1);
        int_drdy = 1'b0; wr_req = 1'b0;

        $display("  test done: total=%0d bad=%0d", checks + mon_checks, bad + mon_bad);
        $finish;
    end

endmodule